// File: doc/BRIEF.md
# Condition Register and Integer Select Unit

This block keeps a small condition register built from eight four-flag fields. It performs two kinds of work. The first is a word compare. A compare checks a register operand either against a second register operand, taken as unsigned, or against a sign-extended 16-bit immediate, taken as signed. The outcome goes into one destination field that the operation names. The second is an integer select without a branch. It reads any single bit of the flattened condition register and returns one of two operands.

A decode stage drives one operation per cycle. Compares take effect on the next rising clock edge. The select result is combinational from the register as it stands now. A select issued in the cycle right after a compare therefore already reads that compare's outcome. When the operand-A register number is zero, the select returns a literal zero in place of operand A.

Top module: `cond_select_unit`

## Requirements
- R1: Condition bit index k of `cr_o` (0..31) is flag position k mod 4 of field k div 4. Inside each field, position 0 is less-than, 1 is greater-than, 2 is equal and 3 is overflow.
- R2: With `op_i` = 2'b01 (register compare), `opa_i` and `opb_i` are compared as unsigned 32-bit numbers.
- R3: A compare changes only the four bits of the field selected by `fld_i`. The other seven fields keep their values.
- R4: With `op_i` = 2'b10 (immediate compare), `imm_i` is sign-extended to 32 bits and compared with `opa_i` as signed numbers.
- R5: After any compare, exactly one of the less-than, greater-than and equal flags of the written field is 1.
- R6: The overflow flag of the written field takes the value `so_i` had in the compare's cycle.
- R7: With `op_i` = 2'b00 (idle) or 2'b11 (select), `cr_o` does not change on the clock edge.
- R8: With `op_i` = 2'b11, `res_o` equals operand A when `cr_o[bit_i]` is 1, and `opb_i` when it is 0.
- R9: During a select with `ra_zero_i` = 1, operand A is the constant 0, whatever `opa_i` holds.
- R10: `res_o` is 0 whenever `op_i` is not 2'b11.
- R11: With `rst` high on a rising edge, `cr_o` becomes 0. This holds even when a compare is requested in that cycle.
- R12: A select in the cycle right after a compare reads the field that compare just wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Operation: 00 idle, 01 register compare, 10 immediate compare, 11 select |
| fld_i | input | 3 | Destination field of a compare |
| bit_i | input | 5 | Condition bit index read by a select |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| ra_zero_i | input | 1 | Operand-A register number is zero |
| imm_i | input | 16 | Immediate of the immediate compare |
| so_i | input | 1 | Summary-overflow value copied into a written field |
| res_o | output | 32 | Select result |
| cr_o | output | 32 | Whole condition register |

## Verification
Register compares use operand pairs whose MSB is set. These give a different result unsigned than signed, so they show that the unsigned ordering is applied. Immediate compares use negative immediates and 16'h8000, which expose a missing sign extension. All eight fields are first loaded with different flag patterns. A select on every one of the 32 bit indices, with distinct A and B values, then shows that each index maps to its own field and flag. Some of these selects have the zero-register indicator set. A long run of mixed compares and selects on pseudo-random values, with idle cycles, a select directly after a compare and a reset during a compare, checks field isolation, overflow capture and the hold behaviour.

// File: rtl/cond_sel_pkg.sv
package cond_sel_pkg;

    localparam int FIELD_W = 4;
    localparam int FLAG_LT = 0;
    localparam int FLAG_GT = 1;
    localparam int FLAG_EQ = 2;
    localparam int FLAG_OV = 3;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_CMP_U  = 2'b01,
        OP_CMP_SI = 2'b10,
        OP_SELECT = 2'b11
    } op_e;

    // Packed so that bit 0 is less-than, bit 3 is overflow.
    typedef struct packed {
        logic ov;
        logic eq;
        logic gt;
        logic lt;
    } crf_t;

endpackage

// File: rtl/cmp_flags.sv
module cmp_flags
    import cond_sel_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic            imm_mode,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [IMMW-1:0] imm,
    input  logic            so,
    output crf_t            flags
);

    logic [XLEN-1:0] rhs;
    logic            less;
    logic            same;

    always_comb begin
        rhs   = imm_mode ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : opb;
        same  = (opa == rhs);
        less  = imm_mode ? ($signed(opa) < $signed(rhs)) : (opa < rhs);
        flags.lt = less;
        flags.eq = same;
        flags.gt = !less && !same;
        flags.ov = so;
    end

endmodule

// File: rtl/cr_store.sv
module cr_store
    import cond_sel_pkg::*;
#(
    parameter int NFIELDS = 8,
    localparam int CRW = FIELD_W * NFIELDS,
    localparam int FW  = $clog2(NFIELDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [FW-1:0]  wr_fld,
    input  crf_t           wr_val,
    output logic [CRW-1:0] cr_q
);

    typedef struct packed {
        logic [CRW-1:0] cr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int f = 0; f < NFIELDS; f++) begin
                if (int'(wr_fld) == f) begin
                    st_d.cr[f*FIELD_W +: FIELD_W] = wr_val;
                end
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cr_q = st_q.cr;

endmodule

// File: rtl/bit_select.sv
module bit_select #(
    parameter int XLEN = 32,
    parameter int CRW  = 32,
    localparam int BW  = $clog2(CRW)
) (
    input  logic            en,
    input  logic [CRW-1:0]  cr,
    input  logic [BW-1:0]   bit_idx,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            ra_zero,
    output logic [XLEN-1:0] res
);

    logic            cond;
    logic [XLEN-1:0] a_eff;

    always_comb begin
        cond  = cr[bit_idx];
        a_eff = ra_zero ? '0 : opa;
        res   = '0;
        if (en) begin
            res = cond ? a_eff : opb;
        end
    end

endmodule

// File: rtl/cond_select_unit.sv
module cond_select_unit
    import cond_sel_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NFIELDS = 8,
    parameter int IMMW    = 16,
    localparam int CRW = FIELD_W * NFIELDS,
    localparam int FW  = $clog2(NFIELDS),
    localparam int BW  = $clog2(CRW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      op_i,
    input  logic [FW-1:0]   fld_i,
    input  logic [BW-1:0]   bit_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic            ra_zero_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            so_i,
    output logic [XLEN-1:0] res_o,
    output logic [CRW-1:0]  cr_o
);

    op_e  op;
    logic is_cmp;
    logic is_imm;
    logic is_sel;
    crf_t cmp_val;

    always_comb begin
        op     = op_e'(op_i);
        is_imm = (op == OP_CMP_SI);
        is_cmp = (op == OP_CMP_U) || is_imm;
        is_sel = (op == OP_SELECT);
    end

    cmp_flags #(.XLEN(XLEN), .IMMW(IMMW)) u_cmp (
        .imm_mode (is_imm),
        .opa      (opa_i),
        .opb      (opb_i),
        .imm      (imm_i),
        .so       (so_i),
        .flags    (cmp_val)
    );

    cr_store #(.NFIELDS(NFIELDS)) u_cr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (is_cmp),
        .wr_fld (fld_i),
        .wr_val (cmp_val),
        .cr_q   (cr_o)
    );

    bit_select #(.XLEN(XLEN), .CRW(CRW)) u_sel (
        .en      (is_sel),
        .cr      (cr_o),
        .bit_idx (bit_i),
        .opa     (opa_i),
        .opb     (opb_i),
        .ra_zero (ra_zero_i),
        .res     (res_o)
    );

endmodule

// File: rtl/cond_select_unit_chk.sv
module cond_select_unit_chk
    import cond_sel_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NFIELDS = 8,
    parameter int IMMW    = 16,
    localparam int CRW = FIELD_W * NFIELDS,
    localparam int FW  = $clog2(NFIELDS),
    localparam int BW  = $clog2(CRW)
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      op_i,
    input logic [FW-1:0]   fld_i,
    input logic [BW-1:0]   bit_i,
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic            ra_zero_i,
    input logic [IMMW-1:0] imm_i,
    input logic            so_i,
    input logic [XLEN-1:0] res_o,
    input logic [CRW-1:0]  cr_o
);

    logic cmp_req;
    assign cmp_req = (op_i == 2'b01) || (op_i == 2'b10);

    // R7: no compare leaves the register untouched
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cmp_req |=> $stable(cr_o));

    // R10: result is zero outside a select
    p_idle_res_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i != 2'b11) |-> (res_o == '0));

    // R9: zero register forces literal zero when the bit is set
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b11 && ra_zero_i && cr_o[bit_i]) |-> (res_o == '0));

    // R8: cleared bit returns operand B
    p_pick_b_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b11 && !cr_o[bit_i]) |-> (res_o == opb_i));

    for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
        // R3: fields not addressed by the compare keep their value
        p_field_keep_r3: assert property (@(posedge clk) disable iff (rst)
            (cmp_req && int'(fld_i) != f)
            |=> (cr_o[f*FIELD_W +: FIELD_W] == $past(cr_o[f*FIELD_W +: FIELD_W])));

        // R5: one ordering flag per written field
        p_one_flag_r5: assert property (@(posedge clk) disable iff (rst)
            (cmp_req && int'(fld_i) == f)
            |=> ($countones(cr_o[f*FIELD_W +: 3]) == 1));

        // R6: overflow flag captures so_i
        p_ov_copy_r6: assert property (@(posedge clk) disable iff (rst)
            (cmp_req && int'(fld_i) == f)
            |=> (cr_o[f*FIELD_W + FLAG_OV] == $past(so_i)));

        // R2: register compare orders unsigned
        p_unsigned_r2: assert property (@(posedge clk) disable iff (rst)
            (op_i == 2'b01 && int'(fld_i) == f)
            |=> (cr_o[f*FIELD_W + FLAG_LT] == ($past(opa_i) < $past(opb_i))));
    end

endmodule

bind cond_select_unit cond_select_unit_chk #(
    .XLEN(XLEN), .NFIELDS(NFIELDS), .IMMW(IMMW)
) u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .fld_i(fld_i), .bit_i(bit_i),
    .opa_i(opa_i), .opb_i(opb_i), .ra_zero_i(ra_zero_i), .imm_i(imm_i),
    .so_i(so_i), .res_o(res_o), .cr_o(cr_o)
);

// File: tb/cond_select_unit_test.sv
`timescale 1ns/1ps
module cond_select_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op_i;
    logic [2:0]  fld_i;
    logic [4:0]  bit_i;
    logic [31:0] opa_i, opb_i;
    logic        ra_zero_i;
    logic [15:0] imm_i;
    logic        so_i;
    logic [31:0] res_o, cr_o;

    always #10 clk = ~clk;

    cond_select_unit uut (
        .clk(clk), .rst(rst), .op_i(op_i), .fld_i(fld_i), .bit_i(bit_i),
        .opa_i(opa_i), .opb_i(opb_i), .ra_zero_i(ra_zero_i), .imm_i(imm_i),
        .so_i(so_i), .res_o(res_o), .cr_o(cr_o)
    );

    typedef struct {
        int          due;
        bit          is_res;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sbq[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] model_cr = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] got;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it  = sbq.pop_front();
            got = it.is_res ? res_o : cr_o;
            checks++;
            if (it.due != cyc || got !== it.exp) begin
                errors++;
                $display("FAIL %s: %s got %h expected %h (cycle %0d)",
                         it.req, it.is_res ? "res_o" : "cr_o", got, it.exp, cyc);
            end
        end
    end

    function automatic logic [3:0] exp_field(bit imm_mode, logic [31:0] a,
                                             logic [31:0] b, logic [15:0] imm,
                                             logic so);
        longint sa, sb;
        logic lt, gt, eq;
        sa = imm_mode ? longint'($signed(a)) : longint'({32'd0, a});
        sb = imm_mode ? longint'($signed(imm)) : longint'({32'd0, b});
        lt = sa < sb;
        gt = sa > sb;
        eq = sa == sb;
        return {so, eq, gt, lt};
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic push(int due, bit is_res, logic [31:0] exp, string req);
        item_t it;
        it.due = due; it.is_res = is_res; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    // Driver: one operation per cycle, driven 2 ns after the edge
    task automatic drive(logic [1:0] op, logic [2:0] fld, logic [4:0] bidx,
                         logic [31:0] a, logic [31:0] b, logic raz,
                         logic [15:0] imm, logic so, string req);
        logic [3:0]  fv;
        logic [31:0] a_eff;
        op_i = op; fld_i = fld; bit_i = bidx; opa_i = a; opb_i = b;
        ra_zero_i = raz; imm_i = imm; so_i = so;
        if (op == 2'b01 || op == 2'b10) begin
            fv = exp_field(op == 2'b10, a, b, imm, so);
            model_cr[4*fld +: 4] = fv;
            push(cyc, 1'b1, 32'd0, "R10");
            push(cyc + 1, 1'b0, model_cr, req);
        end else if (op == 2'b11) begin
            a_eff = raz ? 32'd0 : a;
            push(cyc, 1'b1, model_cr[bidx] ? a_eff : b, req);
            push(cyc + 1, 1'b0, model_cr, "R7");
        end else begin
            push(cyc, 1'b1, 32'd0, "R10");
            push(cyc + 1, 1'b0, model_cr, "R7");
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete (got hang, expected end)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = 2'b00; fld_i = '0; bit_i = '0; opa_i = '0;
        opb_i = '0; ra_zero_i = 1'b0; imm_i = '0; so_i = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        push(cyc, 1'b0, 32'd0, "R11");
        rst = 1'b0;
        @(posedge clk); #2;

        // R12/R8: compare then select on the next cycle (CR7 EQ is bit 30)
        drive(2'b01, 3'd7, 5'd0, 32'd35, 32'd35, 1'b0, 16'd0, 1'b0, "R3");
        drive(2'b11, 3'd0, 5'd30, 32'd1, 32'd0, 1'b0, 16'd0, 1'b0, "R12");
        drive(2'b11, 3'd0, 5'd28, 32'd1, 32'd7, 1'b0, 16'd0, 1'b0, "R8");
        // R2: MSB-set operand is larger unsigned; R6 overflow captured
        drive(2'b01, 3'd0, 5'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 16'd0, 1'b1, "R2");
        drive(2'b11, 3'd0, 5'd1, 32'hAAAA_0001, 32'h5555, 1'b0, 16'd0, 1'b0, "R2");
        drive(2'b11, 3'd0, 5'd3, 32'hCAFE_0003, 32'h0, 1'b0, 16'd0, 1'b0, "R6");
        drive(2'b01, 3'd2, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 16'd0, 1'b0, "R2");
        // R4: negative immediate and 16'h8000 need sign extension
        drive(2'b10, 3'd3, 5'd0, 32'hFFFF_FFFB, 32'h0, 1'b0, 16'hFFFB, 1'b0, "R4");
        drive(2'b10, 3'd5, 5'd0, 32'd1, 32'hFFFF_FFFF, 1'b0, 16'h8000, 1'b1, "R4");
        drive(2'b10, 3'd6, 5'd0, 32'hFFFF_0000, 32'h0, 1'b0, 16'h7FFF, 1'b0, "R4");
        drive(2'b11, 3'd0, 5'd24, 32'h600D, 32'hBAD, 1'b0, 16'd0, 1'b0, "R4");
        // R7/R10: idle cycles with toggling inputs
        drive(2'b00, 3'd1, 5'd2, 32'h1, 32'h2, 1'b1, 16'h3, 1'b1, "R7");
        drive(2'b00, 3'd4, 5'd9, 32'h9, 32'h8, 1'b0, 16'h7, 1'b0, "R10");

        // R1/R5: load all eight fields with different patterns
        for (int f = 0; f < 8; f++) begin
            drive(2'b01, 3'(f), 5'd0, 32'd10, 32'(8 + (f % 3) * 2), 1'b0,
                  16'd0, 1'(f[0]), "R5");
        end
        // R1/R8/R9: select on every bit index
        for (int i = 0; i < 32; i++) begin
            drive(2'b11, 3'd0, 5'(i), 32'hA000_0000 + 32'(i),
                  32'h0B00_0000 + 32'(i), (i % 5) == 0, 16'd0, 1'b0,
                  (i % 5) == 0 ? "R9" : "R1");
        end

        // R11: reset during a compare clears the register
        rst = 1'b1; op_i = 2'b01; fld_i = 3'd4; opa_i = 32'd1; opb_i = 32'd2;
        so_i = 1'b1;
        model_cr = '0;
        push(cyc + 1, 1'b0, 32'd0, "R11");
        @(posedge clk); #2;
        rst = 1'b0;

        // R3/R5/R6: mixed pseudo-random traffic
        for (int n = 0; n < 200; n++) begin
            logic [31:0] r1, r2;
            lfsr = next_rand(lfsr); r1 = lfsr;
            lfsr = next_rand(lfsr); r2 = lfsr;
            case (r1[1:0])
                2'b00: drive(2'b01, r1[4:2], 5'd0, r2, r2 ^ {28'd0, r1[8:5]} ^
                             (r1[9] ? 32'h8000_0000 : 32'd0), 1'b0, 16'd0, r1[10], "R3");
                2'b01: drive(2'b10, r1[4:2], 5'd0, r2, 32'd0, 1'b0,
                             r1[9] ? r2[15:0] : r1[31:16], r1[10], "R4");
                2'b10: drive(2'b11, 3'd0, r1[6:2], r2, ~r2, r1[11], 16'd0, 1'b0, "R8");
                default: drive(2'b00, r1[4:2], r1[6:2], r2, r1, 1'b0, r2[15:0], r1[10], "R7");
            endcase
        end

        op_i = 2'b00;
        repeat (3) @(posedge clk);
        #2;
        if (sbq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left (expected 0)", sbq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule